// File: doc/BRIEF.md
# Reset-Strapped Debug Mode Controller

This block decides whether a processor core may ever enter its privileged debug mode, and when it does. It owns the release of the core's soft reset. After hard reset is removed, it counts down a programmable number of cycles and then releases soft reset. Three clocks before that release it samples a strap taken from the debug clock pin. The sampled value becomes the debug-enable state, and it holds until the next hard reset.

On the first clock after release, the block issues one of two pulses. If the strap was latched as enabled and the pin is still held, it issues a breakpoint-from-reset pulse. Otherwise it issues a request to fetch the reset vector. The two are never issued together.

Once the core is running, the block gates debug entry. Each cause event has its own enable bit, and the block records which events caused the entry. Events that do not cause entry are passed on as ordinary interrupts. While debug is disabled, the enable bits only drive a freeze output. The block also decides whether a development-support register access is allowed, based on debug state and the problem-state bit. The core, the watchpoint comparators and the serial port shifter lie outside the block.

Top module: `dbgstrap_ctrl`

## Requirements
- R1: After hard reset is removed, `sreset_n_o` rises at the (L+1)-th rising clock edge that has `rst_n` high. L is `rel_len`, except that a value below 4 is treated as 4. `sreset_n_o` then stays high until the next hard reset.
- R2: The strap `dsck_i` is sampled at exactly one edge: edge L-2, which is three edges before the release edge. `dbg_en_o` takes the sampled value. The level of `dsck_i` at any other edge has no effect on `dbg_en_o`.
- R3: Hard reset clears `dbg_en_o`. Once soft reset is released, `dbg_en_o` does not change until the next hard reset.
- R4: `fetch_vec_o` and `reset_bkpt_o` are valid for the one cycle after edge L+2. `reset_bkpt_o` is 1 when `dbg_en_o` is 1 and `dsck_i` is still 1 at that edge. Otherwise `fetch_vec_o` is 1. The two are never 1 together, and both are 0 in every other cycle.
- R5: A breakpoint-from-reset pulse puts the core in debug mode at the next edge: `in_dbg_o` and `dbg_entry_o` are 1 after edge L+3.
- R6: Debug entry happens at an edge when all of the following hold: soft reset is released, `dbg_en_o` is 1, the core is not already in debug, and `evt_pend_i & evt_en_i` is nonzero. After that edge, `in_dbg_o` is 1, `dbg_entry_o` is 1 for that one cycle, and the set bits of `evt_pend_i & evt_en_i` are ORed into `cause_o`.
- R7: While `dbg_en_o` is 0, `in_dbg_o` stays 0 whatever events arrive. In that state `irq_o` equals `evt_pend_i`, and `freeze_o` is the OR of `evt_pend_i & evt_en_i`. Both are combinational.
- R8: While `dbg_en_o` is 1, `irq_o` equals `evt_pend_i & ~evt_en_i`, in the same cycle. While `sreset_n_o` is 0, `irq_o` is all zero.
- R9: `dbg_ret_i` high while in debug clears `in_dbg_o` at the next edge. Each 1 bit of `cause_clr_i` clears the same bit of `cause_o` at the next edge. `cause_o` bits are kept otherwise.
- R10: `acc_ok_o` is `acc_req_i & (in_dbg_o | ~msr_pr_i)`, combinational. A problem-state access (`msr_pr_i` = 1) is refused unless the core is in debug.
- R11: `freeze_o` is 1 in every cycle that `in_dbg_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| rel_len | input | CW | Soft-reset length in cycles, read while hard reset is held; minimum 4 |
| dsck_i | input | 1 | Debug clock pin used as the enable strap |
| evt_pend_i | input | NEV | Pending debug cause events |
| evt_en_i | input | NEV | Per-event enable bits |
| dbg_ret_i | input | 1 | Return from debug mode |
| cause_clr_i | input | NEV | Write-one-clear strobe for the recorded causes |
| acc_req_i | input | 1 | Development-support register access request |
| msr_pr_i | input | 1 | Core problem-state bit (1 = user) |
| sreset_n_o | output | 1 | Soft reset to the core, active low |
| dbg_en_o | output | 1 | Latched debug-enable strap |
| fetch_vec_o | output | 1 | One-cycle reset-vector fetch request |
| reset_bkpt_o | output | 1 | One-cycle breakpoint-from-reset request |
| in_dbg_o | output | 1 | Core is in debug mode |
| dbg_entry_o | output | 1 | One-cycle debug entry strobe |
| cause_o | output | NEV | Recorded entry causes |
| irq_o | output | NEV | Events passed on as ordinary interrupts |
| freeze_o | output | 1 | Freeze request |
| acc_ok_o | output | 1 | Register access granted |

## Verification
The reset results follow the count of rising edges after hard reset is removed:
- the strap latches at edge L-2;
- soft reset releases at edge L+1;
- the start pulse appears at edge L+2;
- debug entry from reset appears at edge L+3.

The bench counts its own edges and samples on the falling edge right after each of these. Event entry, return and cause clearing take effect one edge after the stimulus, so they are checked on the next falling edge. The interrupt, freeze and access outputs are combinational, so they are checked a short delay after the inputs change and before the next rising edge.

// File: rtl/dbg_pkg.sv
// Shared constants for the reset-strapped debug controller.
// Assumes nothing beyond a synchronous single-clock design.
package dbg_pkg;
    // Shortest soft-reset hold the sequencer allows.
    localparam int MIN_REL  = 4;
    // Counter value at which the strap is sampled (edges before release).
    localparam int STRAP_AT = 3;
endpackage

// File: rtl/dbg_rst_seq.sv
// Soft-reset sequencer and strap latch.
// What it does:
//   - Loads the soft-reset length while hard reset is held, clamped to MIN_REL.
//   - Counts down once hard reset is removed.
//   - Samples the strap when the count reaches STRAP_AT.
//   - Releases soft reset at the edge after the count reaches zero.
//   - On the next edge, issues either a reset-vector fetch pulse or a
//     breakpoint-from-reset pulse.
// Assumes: rel_len is stable while rst_n is low; CW is at least 3.
module dbg_rst_seq
    import dbg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rel_len,
    input  logic          dsck_i,
    output logic          sreset_n_o,
    output logic          dbg_en_o,
    output logic          fetch_vec_o,
    output logic          reset_bkpt_o
);
    localparam logic [CW-1:0] MIN_LEN = CW'(MIN_REL);
    localparam logic [CW-1:0] TAP     = CW'(STRAP_AT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len_eff;
    logic          first;

    // Clamp the programmed length to the allowed minimum.
    always_comb len_eff = (rel_len < MIN_LEN) ? MIN_LEN : rel_len;

    // Down-counter that times the soft-reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= len_eff;
            sreset_n_o <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (!sreset_n_o) begin
            sreset_n_o <= 1'b1;
        end
    end

    // Strap latch: one sample, three edges before release, held until hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_en_o <= 1'b0;
        else if (!sreset_n_o && cnt == TAP)
            dbg_en_o <= dsck_i;
    end

    // Marks the edge that follows the release edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first <= 1'b0;
        else
            first <= (cnt == '0) && !sreset_n_o;
    end

    // Post-release strap check: choose breakpoint entry or the vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_bkpt_o <= 1'b0;
            fetch_vec_o  <= 1'b0;
        end else begin
            reset_bkpt_o <= first && dbg_en_o && dsck_i;
            fetch_vec_o  <= first && !(dbg_en_o && dsck_i);
        end
    end

    // R1: once released, soft reset is not reasserted without a hard reset.
    p_release_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sreset_n_o) |-> sreset_n_o);

    // R3: the strap value is frozen while the core runs.
    p_strap_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_n_o |-> $stable(dbg_en_o));

    // R4: only one of the two start requests is issued.
    p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_vec_o && reset_bkpt_o));

    // R4: a breakpoint from reset needs the latched enable.
    p_bkpt_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_bkpt_o |-> dbg_en_o);
endmodule

// File: rtl/dbg_entry_gate.sv
// Debug entry gate and cause recorder.
// What it does:
//   - Enters debug on an enabled pending event or on a breakpoint from reset,
//     but only when debug is enabled.
//   - Records the entry causes; software clears them by writing ones.
//   - Routes the other events to ordinary interrupts.
//   - Drives freeze while in debug, or on an enabled event while debug is
//     disabled.
// Assumes: all inputs are synchronous to clk.
module dbg_entry_gate #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sreset_n_i,
    input  logic           dbg_en_i,
    input  logic           reset_bkpt_i,
    input  logic [NEV-1:0] evt_pend_i,
    input  logic [NEV-1:0] evt_en_i,
    input  logic           dbg_ret_i,
    input  logic [NEV-1:0] cause_clr_i,
    output logic           in_dbg_o,
    output logic           dbg_entry_o,
    output logic [NEV-1:0] cause_o,
    output logic [NEV-1:0] irq_o,
    output logic           freeze_o
);
    logic [NEV-1:0] hit;
    logic           enter;

    // Enabled pending events and the entry decision.
    always_comb begin
        hit   = evt_pend_i & evt_en_i;
        enter = sreset_n_i && dbg_en_i && !in_dbg_o && ((|hit) || reset_bkpt_i);
    end

    // Debug state: set on entry, cleared only by an explicit return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_dbg_o <= 1'b0;
        else if (enter)
            in_dbg_o <= 1'b1;
        else if (in_dbg_o && dbg_ret_i)
            in_dbg_o <= 1'b0;
    end

    // One-cycle entry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_entry_o <= 1'b0;
        else
            dbg_entry_o <= enter;
    end

    // Cause record: write-one-clear, and new causes are set on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_o <= '0;
        else
            cause_o <= (cause_o & ~cause_clr_i) | (enter ? hit : '0);
    end

    // Interrupt routing and freeze request.
    always_comb begin
        if (!sreset_n_i)
            irq_o = '0;
        else if (dbg_en_i)
            irq_o = evt_pend_i & ~evt_en_i;
        else
            irq_o = evt_pend_i;
        freeze_o = in_dbg_o || (sreset_n_i && !dbg_en_i && (|hit));
    end

    // R7: debug mode is never held without the strap enable.
    p_no_dbg_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg_o |-> dbg_en_i);

    // R6: the entry strobe coincides with being in debug.
    p_strobe_in_dbg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry_o |-> in_dbg_o);

    // R9: a return while in debug leaves debug at the next edge.
    p_return_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg_o && dbg_ret_i) |=> !in_dbg_o);

    // R11: freeze covers every debug cycle.
    p_freeze_in_dbg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg_o |-> freeze_o);
endmodule

// File: rtl/dbg_acc_gate.sv
// Development-support register access gate.
// What it does:
//   - Grants every access while the core is in debug.
//   - Otherwise grants only supervisor-state accesses (problem-state bit clear).
// Assumes: the request and privilege bit are valid in the same cycle.
module dbg_acc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req_i,
    input  logic msr_pr_i,
    input  logic in_dbg_i,
    output logic acc_ok_o
);
    // Privilege and debug-state check.
    always_comb acc_ok_o = acc_req_i && (in_dbg_i || !msr_pr_i);

    // R10: a user access outside debug is refused.
    p_user_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_pr_i && !in_dbg_i) |-> !acc_ok_o);

    // R10: no grant without a request.
    p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok_o |-> acc_req_i);
endmodule

// File: rtl/dbgstrap_ctrl.sv
// Top level of the reset-strapped debug controller.
// What it does: wires the soft-reset sequencer, the debug entry gate and the
//   register access gate together.
// Assumes: a single clock and a synchronous active-low hard reset.
module dbgstrap_ctrl #(
    parameter int CW  = 8,
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  rel_len,
    input  logic           dsck_i,
    input  logic [NEV-1:0] evt_pend_i,
    input  logic [NEV-1:0] evt_en_i,
    input  logic           dbg_ret_i,
    input  logic [NEV-1:0] cause_clr_i,
    input  logic           acc_req_i,
    input  logic           msr_pr_i,
    output logic           sreset_n_o,
    output logic           dbg_en_o,
    output logic           fetch_vec_o,
    output logic           reset_bkpt_o,
    output logic           in_dbg_o,
    output logic           dbg_entry_o,
    output logic [NEV-1:0] cause_o,
    output logic [NEV-1:0] irq_o,
    output logic           freeze_o,
    output logic           acc_ok_o
);
    dbg_rst_seq #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rel_len      (rel_len),
        .dsck_i       (dsck_i),
        .sreset_n_o   (sreset_n_o),
        .dbg_en_o     (dbg_en_o),
        .fetch_vec_o  (fetch_vec_o),
        .reset_bkpt_o (reset_bkpt_o)
    );

    dbg_entry_gate #(.NEV(NEV)) u_entry (
        .clk          (clk),
        .rst_n        (rst_n),
        .sreset_n_i   (sreset_n_o),
        .dbg_en_i     (dbg_en_o),
        .reset_bkpt_i (reset_bkpt_o),
        .evt_pend_i   (evt_pend_i),
        .evt_en_i     (evt_en_i),
        .dbg_ret_i    (dbg_ret_i),
        .cause_clr_i  (cause_clr_i),
        .in_dbg_o     (in_dbg_o),
        .dbg_entry_o  (dbg_entry_o),
        .cause_o      (cause_o),
        .irq_o        (irq_o),
        .freeze_o     (freeze_o)
    );

    dbg_acc_gate u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req_i (acc_req_i),
        .msr_pr_i  (msr_pr_i),
        .in_dbg_i  (in_dbg_o),
        .acc_ok_o  (acc_ok_o)
    );

    // R5: a breakpoint from reset is followed by debug entry.
    p_bkpt_enters_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_bkpt_o |=> (in_dbg_o && dbg_entry_o));
endmodule

// File: tb/dbgstrap_ctrl_test.sv
// Self-checking bench for dbgstrap_ctrl: a vector table for the combinational
// routing while debug is disabled, then directed reset and entry tests.
module dbgstrap_ctrl_test;
    localparam int PERIOD = 10;
    localparam int L      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rel_len = 8'(L);
    logic       dsck_i = 1'b0;
    logic [3:0] evt_pend_i = '0;
    logic [3:0] evt_en_i = '0;
    logic       dbg_ret_i = 1'b0;
    logic [3:0] cause_clr_i = '0;
    logic       acc_req_i = 1'b0;
    logic       msr_pr_i = 1'b0;
    logic       sreset_n_o, dbg_en_o, fetch_vec_o, reset_bkpt_o;
    logic       in_dbg_o, dbg_entry_o, freeze_o, acc_ok_o;
    logic [3:0] cause_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    dbgstrap_ctrl uut (.*);

    // Vector fields: [15:12] pend, [11:8] en, [7] pr, [6] req,
    // [5:2] expected irq, [1] expected freeze, [0] expected grant.
    localparam logic [15:0] VEC [6] = '{
        16'b0001_0001_0_1_0001_1_1,
        16'b0110_0001_1_1_0110_0_0,
        16'b1000_1111_1_0_1000_1_0,
        16'b0000_1111_0_1_0000_0_1,
        16'b1111_0000_0_0_1111_0_0,
        16'b0101_0100_1_1_0101_1_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold hard reset for two edges, then release it at a falling edge.
    task automatic hard_reset(input logic [7:0] len);
        rst_n   = 1'b0;
        rel_len = len;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Test A: strap low throughout, L = 6.
        evt_pend_i = 4'b1111;
        hard_reset(8'(L));
        chk("R1 reset sreset low", 32'(sreset_n_o), 0);
        chk("R3 reset dbg_en clear", 32'(dbg_en_o), 0);
        chk("R8 irq masked in soft reset", 32'(irq_o), 0);
        evt_pend_i = '0;
        for (int k = 1; k <= L; k++) tick();
        chk("R1 still held at edge L", 32'(sreset_n_o), 0);
        tick();
        chk("R1 released at edge L+1", 32'(sreset_n_o), 1);
        chk("R2 strap low latched", 32'(dbg_en_o), 0);
        tick();
        chk("R4 fetch pulse", 32'(fetch_vec_o), 1);
        chk("R4 no bkpt", 32'(reset_bkpt_o), 0);
        tick();
        chk("R4 fetch one cycle", 32'(fetch_vec_o), 0);

        // Vector table, debug disabled: R7 routing, R10 access.
        for (int i = 0; i < 6; i++) begin
            evt_pend_i = VEC[i][15:12];
            evt_en_i   = VEC[i][11:8];
            msr_pr_i   = VEC[i][7];
            acc_req_i  = VEC[i][6];
            #1;
            chk("R7 irq", 32'(irq_o), 32'(VEC[i][5:2]));
            chk("R7 freeze", 32'(freeze_o), 32'(VEC[i][1]));
            chk("R10 access", 32'(acc_ok_o), 32'(VEC[i][0]));
            tick();
            chk("R7 no debug entry", 32'(in_dbg_o), 0);
        end
        evt_pend_i = '0; evt_en_i = '0; acc_req_i = 0; msr_pr_i = 0;

        // Test B: strap high only at edge L-2.
        hard_reset(8'(L));
        for (int k = 1; k <= L + 1; k++) begin
            dsck_i = (k == L - 2);
            tick();
        end
        dsck_i = 1'b0;
        chk("R2 strap sampled at edge L-2", 32'(dbg_en_o), 1);
        chk("R1 released", 32'(sreset_n_o), 1);
        tick();
        chk("R4 fetch when strap dropped", 32'(fetch_vec_o), 1);
        chk("R4 no bkpt when strap dropped", 32'(reset_bkpt_o), 0);
        evt_pend_i = 4'b0101; evt_en_i = 4'b0010;
        #1;
        chk("R8 irq unenabled events", 32'(irq_o), 32'h5);
        tick();
        chk("R6 no entry without enabled event", 32'(in_dbg_o), 0);
        evt_pend_i = 4'b0010;
        #1;
        chk("R8 enabled event not routed", 32'(irq_o), 0);
        tick();
        evt_pend_i = '0;
        chk("R6 entered debug", 32'(in_dbg_o), 1);
        chk("R6 entry strobe", 32'(dbg_entry_o), 1);
        chk("R6 cause recorded", 32'(cause_o), 32'h2);
        chk("R11 freeze in debug", 32'(freeze_o), 1);
        acc_req_i = 1; msr_pr_i = 1;
        #1;
        chk("R10 user access in debug", 32'(acc_ok_o), 1);
        tick();
        chk("R6 strobe one cycle", 32'(dbg_entry_o), 0);
        dbg_ret_i = 1;
        tick();
        dbg_ret_i = 0;
        chk("R9 return leaves debug", 32'(in_dbg_o), 0);
        chk("R9 cause kept", 32'(cause_o), 32'h2);
        chk("R10 user refused outside debug", 32'(acc_ok_o), 0);
        cause_clr_i = 4'b0010;
        tick();
        cause_clr_i = '0;
        chk("R9 cause cleared", 32'(cause_o), 0);
        acc_req_i = 0; msr_pr_i = 0;

        // Test C: strap high everywhere except edge L-2.
        hard_reset(8'(L));
        for (int k = 1; k <= L + 1; k++) begin
            dsck_i = (k != L - 2);
            tick();
        end
        chk("R2 other edges ignored", 32'(dbg_en_o), 0);
        tick();
        chk("R4 fetch when disabled though pin held", 32'(fetch_vec_o), 1);
        tick();
        chk("R7 no debug when disabled", 32'(in_dbg_o), 0);

        // Test D: strap held through release.
        dsck_i = 1'b1;
        hard_reset(8'(L));
        for (int k = 1; k <= L + 2; k++) tick();
        chk("R4 bkpt from reset", 32'(reset_bkpt_o), 1);
        chk("R4 no fetch with bkpt", 32'(fetch_vec_o), 0);
        tick();
        chk("R5 debug from reset", 32'(in_dbg_o), 1);
        chk("R5 entry strobe", 32'(dbg_entry_o), 1);
        chk("R4 bkpt one cycle", 32'(reset_bkpt_o), 0);
        dsck_i = 1'b0;

        // Test E: length below minimum clamps to 4; hard reset clears enable.
        rst_n = 1'b0;
        rel_len = 8'd2;
        tick();
        chk("R3 hard reset clears enable", 32'(dbg_en_o), 0);
        tick();
        rst_n = 1'b1;
        for (int k = 1; k <= 4; k++) tick();
        chk("R1 clamp held at edge 4", 32'(sreset_n_o), 0);
        tick();
        chk("R1 clamp released at edge 5", 32'(sreset_n_o), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule